// File: doc/BRIEF.md
# Halfword multiply-accumulate long unit

This unit decodes and executes one signed halfword multiply with a 64-bit accumulate. The caller supplies a 32-bit instruction word, a flag saying which of two encodings applies, and the contents of four source registers: the two multiplicands and the low and high words of the accumulator. The unit takes one signed 16-bit half from each multiplicand, and a separate select bit in the instruction chooses the half for each operand. It multiplies the two halves, sign-extends the 32-bit product and adds it to the 64-bit accumulator.

The results are the new low and high accumulator words, the register indices they go to, a match flag and the instruction's condition code. All of these are registered, so they appear one clock after an input strobe. The condition is not evaluated here. Hazards and the register file belong to the surrounding pipeline.

Top module: `hmacl_unit`

## Requirements
- R1: Each multiplicand is a signed 16-bit value. Its select bit picks bits [15:0] of the source register when it is 0 and bits [31:16] when it is 1. The other half has no effect on the result.
- R2: Select bit N applies to the first multiplicand (`rn_val`). Select bit M applies to the second (`rm_val`). This allows all four top/bottom combinations.
- R3: The signed product is sign-extended to 64 bits and added to {`hi_val`,`lo_val`}. The sum wraps modulo 2^64, and no overflow indication exists.
- R4: With `enc_wide`=1, the word matches when bits [31:20]=12'b111110111100 and bits [7:6]=2'b10.
- R5: In the wide form, the first-multiplicand index is [19:16], the low destination is [15:12], the high destination is [11:8], N is bit 5, M is bit 4 and the second-multiplicand index is [3:0].
- R6: With `enc_wide`=0, the word matches when bits [27:20]=8'b00010100, bit 7=1 and bit 4=0.
- R7: In the conditional form, the condition is [31:28], the high destination is [19:16], the low destination is [15:12], M is bit 6, N is bit 5 and the first-multiplicand index is [3:0].
- R8: When the word does not match the selected encoding, `hit`, `lo_we` and `hi_we` are low. When it matches, all three are high.
- R9: `cond_out` carries bits [31:28] in the conditional form and 4'b1110 (always) in the wide form.
- R10: Outputs appear one clock after `in_valid`. `out_valid` is high only in the cycle after a strobe. A synchronous active-high `rst` clears `out_valid`, `hit` and both write enables.
- R11: `lo_res` is sum bits [31:0] and goes to index `lo_idx`. `hi_res` is sum bits [63:32] and goes to index `hi_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| enc_wide | input | 1 | 1 = wide form, 0 = conditional form |
| instr | input | 32 | Instruction word |
| rn_val | input | 32 | First multiplicand register |
| rm_val | input | 32 | Second multiplicand register |
| lo_val | input | 32 | Accumulator low word |
| hi_val | input | 32 | Accumulator high word |
| out_valid | output | 1 | Result valid |
| hit | output | 1 | Word matched the selected encoding |
| lo_we | output | 1 | Write enable, low word |
| hi_we | output | 1 | Write enable, high word |
| lo_idx | output | 4 | Destination index, low word |
| hi_idx | output | 4 | Destination index, high word |
| lo_res | output | 32 | New low word |
| hi_res | output | 32 | New high word |
| cond_out | output | 4 | Condition code for an external check |

## Verification
The bench builds the unit with its default parameters: 32-bit register words and 4-bit register indices. With these values, both 16-bit extremes (-32768 squared) can be reached, as can a carry out of bit 63 of the accumulator. Random words in both encodings vary the unused halves independently of the selected halves. Mismatched words then show that the write enables stay low.

// File: rtl/hmacl_unit.sv
module hmacl_unit #(
  parameter int DW = 32,
  parameter int IW = 4,
  parameter logic [3:0] ALWAYS_CC = 4'b1110
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          enc_wide,
  input  logic [31:0]   instr,
  input  logic [DW-1:0] rn_val,
  input  logic [DW-1:0] rm_val,
  input  logic [DW-1:0] lo_val,
  input  logic [DW-1:0] hi_val,
  output logic          out_valid,
  output logic          hit,
  output logic          lo_we,
  output logic          hi_we,
  output logic [IW-1:0] lo_idx,
  output logic [IW-1:0] hi_idx,
  output logic [DW-1:0] lo_res,
  output logic [DW-1:0] hi_res,
  output logic [3:0]    cond_out
);
  localparam int HW = DW / 2;
  localparam int AW = 2 * DW;

  logic wide_ok, cond_ok, match, sel_n, sel_m;
  logic signed [HW-1:0] op_a, op_b;
  logic signed [DW-1:0] prod;
  logic [AW-1:0] sum;
  logic hit_q;

  assign wide_ok = (instr[31:20] == 12'b1111_1011_1100) && (instr[7:6] == 2'b10);
  assign cond_ok = (instr[27:20] == 8'b0001_0100) && instr[7] && !instr[4];
  assign match   = enc_wide ? wide_ok : cond_ok;

  assign sel_n = instr[5];
  assign sel_m = enc_wide ? instr[4] : instr[6];

  assign op_a = sel_n ? rn_val[DW-1:HW] : rn_val[HW-1:0];
  assign op_b = sel_m ? rm_val[DW-1:HW] : rm_val[HW-1:0];
  assign prod = DW'(op_a) * DW'(op_b);
  assign sum  = {hi_val, lo_val} + {{DW{prod[DW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      hit_q     <= 1'b0;
      lo_idx    <= '0;
      hi_idx    <= '0;
      lo_res    <= '0;
      hi_res    <= '0;
      cond_out  <= ALWAYS_CC;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        hit_q    <= match;
        lo_idx   <= IW'(instr[15:12]);
        hi_idx   <= enc_wide ? IW'(instr[11:8]) : IW'(instr[19:16]);
        lo_res   <= sum[DW-1:0];
        hi_res   <= sum[AW-1:DW];
        cond_out <= enc_wide ? ALWAYS_CC : instr[31:28];
      end
    end
  end

  assign hit   = out_valid & hit_q;
  assign lo_we = hit;
  assign hi_we = hit;
endmodule

// File: rtl/hmacl_unit_chk.sv
module hmacl_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        enc_wide,
  input logic        out_valid,
  input logic        hit,
  input logic        lo_we,
  input logic        hi_we,
  input logic [31:0] lo_res,
  input logic [3:0]  cond_out
);
  p_latency_r10: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(lo_res));
  p_we_hit_r8: assert property (@(posedge clk) disable iff (rst) (lo_we || hi_we) |-> (hit && out_valid));
  p_we_pair_r8: assert property (@(posedge clk) disable iff (rst) hit |-> (lo_we && hi_we));
  p_wide_cc_r9: assert property (@(posedge clk) disable iff (rst) (in_valid && enc_wide) |=> cond_out == 4'b1110);
endmodule

bind hmacl_unit hmacl_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .enc_wide(enc_wide),
  .out_valid(out_valid), .hit(hit), .lo_we(lo_we), .hi_we(hi_we),
  .lo_res(lo_res), .cond_out(cond_out)
);

// File: tb/tb_hmacl_unit.sv
module tb_hmacl_unit;
  logic clk = 0, rst = 1, in_valid = 0, enc_wide = 0;
  logic [31:0] instr = 0, rn_val = 0, rm_val = 0, lo_val = 0, hi_val = 0;
  logic out_valid, hit, lo_we, hi_we;
  logic [3:0] lo_idx, hi_idx, cond_out;
  logic [31:0] lo_res, hi_res;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hmacl_unit dut (.*);

  function automatic logic [31:0] mk_wide(logic [3:0] rn, logic [3:0] rlo, logic [3:0] rhi,
                                          logic n, logic m, logic [3:0] rm);
    return {12'b1111_1011_1100, rn, rlo, rhi, 2'b10, n, m, rm};
  endfunction

  function automatic logic [31:0] mk_cond(logic [3:0] cc, logic [3:0] rhi, logic [3:0] rlo,
                                          logic [3:0] rm, logic m, logic n, logic [3:0] rn);
    return {cc, 8'b0001_0100, rhi, rlo, rm, 1'b1, m, n, 1'b0, rn};
  endfunction

  function automatic logic [63:0] ref_sum(logic [31:0] a, logic [31:0] b, logic ta, logic tb,
                                          logic [63:0] acc);
    logic signed [15:0] x = ta ? a[31:16] : a[15:0];
    logic signed [15:0] y = tb ? b[31:16] : b[15:0];
    logic signed [63:0] p = 64'(x) * 64'(y);
    return acc + p;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic wide, logic [31:0] w, logic [31:0] a, logic [31:0] b,
                     logic [63:0] acc, bit exp_hit, logic n, logic m,
                     logic [3:0] e_lo, logic [3:0] e_hi, logic [3:0] e_cc);
    logic [63:0] e;
    e = ref_sum(a, b, n, m, acc);
    enc_wide = wide; instr = w; rn_val = a; rm_val = b;
    lo_val = acc[31:0]; hi_val = acc[63:32]; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid === 1'b1, "R10", 64'(out_valid), 64'd1);
    chk(hit === exp_hit && lo_we === exp_hit && hi_we === exp_hit,
        wide ? "R4/R8" : "R6/R8", {hit, lo_we, hi_we}, {3{exp_hit}});
    if (exp_hit) begin
      chk({hi_res, lo_res} === e, "R1/R2/R3/R11", {hi_res, lo_res}, e);
      chk(lo_idx === e_lo && hi_idx === e_hi, wide ? "R5" : "R7",
          {lo_idx, hi_idx}, {e_lo, e_hi});
      chk(cond_out === e_cc, "R9", 64'(cond_out), 64'(e_cc));
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(out_valid === 0 && lo_we === 0 && hi_we === 0, "R10", {out_valid, lo_we, hi_we}, 0);
    rst = 0;
    @(negedge clk);
    chk(out_valid === 0, "R10", 64'(out_valid), 0);

    // corner cases
    run(1, mk_wide(1, 2, 3, 0, 0, 4), 32'h1234_8000, 32'hABCD_8000, 0, 1, 0, 0, 2, 3, 4'he);
    run(0, mk_cond(4'h3, 7, 6, 1, 1, 1, 9), 32'h8000_0000, 32'h8000_0000, 64'h1, 1, 1, 1, 6, 7, 4'h3);
    run(1, mk_wide(0, 5, 6, 1, 0, 0), 32'h7FFF_0000, 32'h0000_7FFF, 64'h7FFF_FFFF_FFFF_FFFF, 1, 1, 0, 5, 6, 4'he);
    run(0, mk_cond(4'h0, 1, 0, 2, 0, 0, 3), 32'h0000_FFFF, 32'h0000_0005, 0, 1, 0, 0, 0, 1, 4'h0);
    run(1, mk_wide(2, 8, 9, 0, 1, 1), 32'h0000_0001, 32'h0001_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, 8, 9, 4'he);
    // R1: other halves changed, same selected halves
    run(0, mk_cond(4'hA, 4, 5, 6, 0, 1, 7), 32'h0003_FFFF, 32'hDEAD_0007, 64'h10, 1, 1, 0, 5, 4, 4'hA);
    run(0, mk_cond(4'hA, 4, 5, 6, 0, 1, 7), 32'h0003_1234, 32'h0000_0007, 64'h10, 1, 1, 0, 5, 4, 4'hA);
    // R8: mismatches
    run(1, mk_wide(1, 2, 3, 0, 0, 4) | 32'h0000_0040, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    run(1, mk_cond(4'hE, 1, 2, 3, 0, 0, 4), 1, 1, 0, 0, 0, 0, 0, 0, 0);
    run(0, mk_cond(4'hE, 1, 2, 3, 0, 0, 4) | 32'h0000_0010, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    run(0, mk_wide(1, 2, 3, 0, 0, 4), 1, 1, 0, 0, 0, 0, 0, 0, 0);
    // random, both encodings, all select combinations
    for (int i = 0; i < 200; i++) begin
      logic [3:0] f1, f2, f3, f4, cc;
      logic n, m, wd;
      logic [63:0] acc;
      f1 = 4'($urandom); f2 = 4'($urandom); f3 = 4'($urandom); f4 = 4'($urandom);
      cc = 4'($urandom); n = 1'($urandom); m = 1'($urandom); wd = 1'($urandom);
      acc = {$urandom, $urandom};
      if (wd)
        run(1, mk_wide(f1, f2, f3, n, m, f4), $urandom, $urandom, acc, 1, n, m, f2, f3, 4'he);
      else
        run(0, mk_cond(cc, f3, f2, f4, m, n, f1), $urandom, $urandom, acc, 1, n, m, f2, f3, cc);
    end
    @(negedge clk);
    chk(out_valid === 0 && lo_we === 0, "R10", {out_valid, lo_we}, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule